// File: doc/BRIEF.md
# Three-Channel DMA Trigger Arbiter

This block sits in front of a shared DMA transfer engine and decides which of three channels may run next. Each channel watches one line out of a wide vector of event sources, and software chooses that line through a per-channel select field. A rising edge on the chosen line is remembered as a pending request for that channel. Pending requests are handed to the engine one at a time through a one-hot grant.

While the memory bus is reserved for another agent, the inhibit input is held high. Examples are a reprogramming window or a non-maskable interrupt. Any trigger that arrives during that time is thrown away. Software sets the order in which simultaneous requests are served. It can choose a fixed ladder or a rotating order in which the channel served last moves to the back.

The engine treats an asserted grant bit as "start and stay busy". It pulses `eng_done` once the transfer is over. That pulse releases the grant and clears the request of the served channel.

Top module: `dma_trig_arb`

## Requirements
- R1: After reset, `grant` is all zeros and no channel holds a pending request. The round-robin history treats channel 2 as the last channel served.
- R2: Channel c takes its trigger from `src_evt[k]`, where k is the value in `chan_sel[c*SEL_W +: SEL_W]`. A source chosen by no channel never causes a grant. Several channels may select the same source.
- R3: A 0-to-1 change on a channel's selected source sets that channel's pending request. A source held high counts as one event only, and it must fall and rise again to trigger again.
- R4: While `inhibit` is high, rising edges are dropped and not stored. A source that rose during inhibit and is still high when inhibit falls does not trigger.
- R5: At most one bit of `grant` is high. From idle, `grant[c]` rises on the second rising clock edge after the selected source goes high, and only for a channel that is pending.
- R6: A grant stays unchanged, with no preemption, until `eng_done` is high on a clock edge. At that edge `grant` returns to zero for at least one cycle and the served channel's request clears. `eng_done` has no effect while no grant is active.
- R7: With `prio_mode` = 0, simultaneous requests are served in the order channel 0, then 1, then 2.
- R8: With `prio_mode` = 1, the search starts at the channel after the most recently granted one and wraps around from 2 to 0.
- R9: Further rising edges on a channel whose request is already pending, before its `eng_done`, do not add a second grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_evt | input | NUM_SRC | Event source lines that triggers are picked from |
| chan_sel | input | 3*SEL_W | Per-channel source index; channel c uses bits [c*SEL_W +: SEL_W] |
| prio_mode | input | 1 | 0 = fixed order 0>1>2, 1 = rotating order |
| inhibit | input | 1 | Bus reserved; triggers are dropped while high |
| eng_done | input | 1 | Transfer engine finished the granted channel |
| grant | output | 3 | One-hot grant to the transfer engine, held until done |

## Verification
A vector table drives different combinations of select fields and source masks. Some sources are selected by one channel, some by several channels, and some by none. The table shows whether the multiplexers route the intended line and whether simultaneous requests come out in ladder order.

Directed sequences follow the table. They hold a source high to separate edge detection from level detection. They raise sources during inhibit, and also hold them across the end of inhibit, to show that dropped triggers are not latched. They pulse a source again while its grant is active to check that requests merge.

Two more sequences cover priority and timing. A single request on channel 0 followed by all three channels at once distinguishes the fixed order (0,1,2) from the rotating order (1,2,0). A cycle-exact check pins the two-edge latency from trigger to grant.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

   localparam int NUM_CH = 3;

   typedef logic [NUM_CH-1:0] ch_vec_t;
   typedef logic [1:0]        ch_idx_t;

   function automatic int sel_width(input int n_src);
      return (n_src > 1) ? $clog2(n_src) : 1;
   endfunction

   function automatic ch_idx_t onehot_to_idx(input ch_vec_t oh);
      ch_idx_t r;
      r = '0;
      for (int i = 0; i < NUM_CH; i++)
         if (oh[i]) r = ch_idx_t'(i);
      return r;
   endfunction

endpackage

// File: rtl/dma_trig_chan.sv
module dma_trig_chan #(
   parameter int NUM_SRC = 16,
   parameter int SEL_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_evt,
   input  logic [SEL_W-1:0]   sel,
   input  logic               inhibit,
   input  logic               clr,
   output logic               pend
);

   localparam logic [SEL_W:0] SRC_LIM = (SEL_W+1)'(NUM_SRC);

   logic sel_bit;
   logic prev_q;
   logic pend_q;
   logic rise;

   // out-of-range select reads as a quiet line
   always_comb begin
      if ({1'b0, sel} < SRC_LIM) sel_bit = src_evt[sel];
      else                       sel_bit = 1'b0;
   end

   assign rise = sel_bit & ~prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         prev_q <= sel_bit;
         // a fresh edge wins over the release of the old request
         pend_q <= (pend_q & ~clr) | (rise & ~inhibit);
      end
   end

   assign pend = pend_q;

   assert_inhibit_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (inhibit && !pend_q) |=> !pend_q);

   assert_edge_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!inhibit && sel_bit && !prev_q) |=> pend_q);

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick
   import dma_arb_pkg::*;
#(
   parameter bit RR_EN = 1'b1
) (
   input  ch_vec_t req,
   input  logic    rr_mode,
   input  ch_idx_t last_idx,
   output ch_vec_t pick
);

   generate
      if (RR_EN) begin : g_rr
         always_comb begin
            int  start;
            int  idx;
            logic found;
            pick  = '0;
            found = 1'b0;
            if (rr_mode) start = (int'(last_idx) >= NUM_CH - 1) ? 0 : int'(last_idx) + 1;
            else         start = 0;
            for (int k = 0; k < NUM_CH; k++) begin
               idx = start + k;
               if (idx >= NUM_CH) idx = idx - NUM_CH;
               if (!found && req[idx]) begin
                  pick[idx] = 1'b1;
                  found     = 1'b1;
               end
            end
         end
      end else begin : g_fixed
         logic unused_rr;
         assign unused_rr = ^{rr_mode, last_idx};
         always_comb begin
            logic found;
            pick  = '0;
            found = 1'b0;
            for (int k = 0; k < NUM_CH; k++) begin
               if (!found && req[k]) begin
                  pick[k] = 1'b1;
                  found   = 1'b1;
               end
            end
         end
      end
   endgenerate

   always_comb begin
      assert_pick_subset_R5: assert ((pick & ~req) == '0);
   end

endmodule

// File: rtl/dma_trig_arb.sv
module dma_trig_arb
   import dma_arb_pkg::*;
#(
   parameter int  NUM_SRC = 16,
   parameter bit  RR_EN   = 1'b1,
   localparam int SEL_W   = sel_width(NUM_SRC)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_SRC-1:0]      src_evt,
   input  logic [NUM_CH*SEL_W-1:0] chan_sel,
   input  logic                    prio_mode,
   input  logic                    inhibit,
   input  logic                    eng_done,
   output logic [NUM_CH-1:0]       grant
);

   generate
      if (NUM_SRC < 2) begin : g_bad_src
         $error("dma_trig_arb: NUM_SRC must be at least 2");
      end
   endgenerate

   ch_vec_t pend;
   ch_vec_t clr;
   ch_vec_t pick;
   ch_vec_t grant_q;
   ch_idx_t last_q;

   assign clr = grant_q & {NUM_CH{eng_done}};

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
         dma_trig_chan #(
            .NUM_SRC (NUM_SRC),
            .SEL_W   (SEL_W)
         ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_evt (src_evt),
            .sel     (chan_sel[c*SEL_W +: SEL_W]),
            .inhibit (inhibit),
            .clr     (clr[c]),
            .pend    (pend[c])
         );
      end
   endgenerate

   dma_prio_pick #(
      .RR_EN (RR_EN)
   ) u_pick (
      .req      (pend),
      .rr_mode  (prio_mode),
      .last_idx (last_q),
      .pick     (pick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_q <= '0;
         last_q  <= ch_idx_t'(NUM_CH - 1);
      end else if (grant_q != '0) begin
         if (eng_done) grant_q <= '0;
      end else if (pend != '0) begin
         grant_q <= pick;
         last_q  <= onehot_to_idx(pick);
      end
   end

   assign grant = grant_q;

   assert_grant_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_q));

   assert_grant_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_q != '0) |-> ((grant_q & pend) == grant_q));

   assert_grant_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_q != '0 && !eng_done) |=> (grant_q == $past(grant_q)));

   assert_grant_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_q != '0 && eng_done) |=> (grant_q == '0));

endmodule

// File: tb/tb_dma_trig_arb.sv
module tb_dma_trig_arb;

   localparam int CLK_P   = 10;
   localparam int NSRC    = 16;
   localparam int SW      = 4;
   localparam int WD_CYC  = 20000;

   typedef struct packed {
      logic [3:0]  s0, s1, s2;
      logic [15:0] mask;
      logic        mode;
      logic [1:0]  n, o0, o1, o2;
   } vec_t;

   // R2/R7 table: selects, raised sources, expected grant order
   localparam vec_t VEC [0:5] = '{
      '{4'd3,  4'd7,  4'd12, 16'h0080, 1'b0, 2'd1, 2'd1, 2'd0, 2'd0},
      '{4'd3,  4'd7,  4'd12, 16'h1008, 1'b1, 2'd2, 2'd0, 2'd2, 2'd0},
      '{4'd5,  4'd5,  4'd5,  16'h0020, 1'b0, 2'd3, 2'd0, 2'd1, 2'd2},
      '{4'd0,  4'd15, 4'd9,  16'h8201, 1'b1, 2'd3, 2'd0, 2'd1, 2'd2},
      '{4'd1,  4'd2,  4'd4,  16'h0100, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0},
      '{4'd2,  4'd1,  4'd0,  16'h0006, 1'b0, 2'd2, 2'd0, 2'd1, 2'd0}
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC-1:0] src_evt = '0;
   logic [3*SW-1:0] chan_sel = '0;
   logic            prio_mode = 1'b0;
   logic            inhibit = 1'b0;
   logic            eng_done = 1'b0;
   logic [2:0]      grant;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_P/2) clk = ~clk;

   dma_trig_arb #(.NUM_SRC(NSRC), .RR_EN(1'b1)) dut (
      .clk (clk), .rst_n (rst_n), .src_evt (src_evt), .chan_sel (chan_sel),
      .prio_mode (prio_mode), .inhibit (inhibit), .eng_done (eng_done),
      .grant (grant)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; src_evt = '0; eng_done = 1'b0; inhibit = 1'b0;
      tick(2);
      rst_n = 1'b1;
      tick(1);
   endtask

   task automatic set_sel(input int a, input int b, input int c);
      chan_sel = {SW'(c), SW'(b), SW'(a)};
   endtask

   task automatic serve(input int ch, input string req);
      int w = 0;
      while (grant == 3'b000 && w < 20) begin
         tick(1);
         w++;
      end
      check(grant == 3'(1 << ch), req, 32'(grant), 32'(1 << ch));
      eng_done = 1'b1;
      tick(1);
      eng_done = 1'b0;
      check(grant == 3'b000, "R6 release", 32'(grant), 32'h0);
   endtask

   task automatic expect_idle(input int n, input string req);
      tick(n);
      check(grant == 3'b000, req, 32'(grant), 32'h0);
   endtask

   initial begin
      repeat (WD_CYC) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      // R1 reset state
      do_reset();
      check(grant == 3'b000, "R1 reset grant", 32'(grant), 32'h0);
      expect_idle(3, "R1 no pending after reset");

      // table walk: R2 routing, R7 simultaneous order
      for (int v = 0; v < 6; v++) begin
         do_reset();
         prio_mode = VEC[v].mode;
         set_sel(int'(VEC[v].s0), int'(VEC[v].s1), int'(VEC[v].s2));
         src_evt = VEC[v].mask;
         if (VEC[v].n > 0) serve(int'(VEC[v].o0), "R2 table first");
         if (VEC[v].n > 1) serve(int'(VEC[v].o1), "R7 table second");
         if (VEC[v].n > 2) serve(int'(VEC[v].o2), "R7 table third");
         expect_idle(5, "R2 table no extra grant");
         src_evt = '0;
      end

      // R5 latency and one-hot
      do_reset();
      prio_mode = 1'b0;
      set_sel(0, 1, 2);
      src_evt[1] = 1'b1;
      tick(1);
      check(grant == 3'b000, "R5 not after one edge", 32'(grant), 32'h0);
      tick(1);
      check(grant == 3'b010, "R5 grant on second edge", 32'(grant), 32'h2);
      // R6 hold without done, no preemption by channel 0
      src_evt[0] = 1'b1;
      tick(4);
      check(grant == 3'b010, "R6 hold no preempt", 32'(grant), 32'h2);
      eng_done = 1'b1;
      tick(1);
      eng_done = 1'b0;
      check(grant == 3'b000, "R6 release", 32'(grant), 32'h0);
      serve(0, "R6 queued after release");
      // R3 level held high gives no second event
      expect_idle(5, "R3 level no retrigger");
      src_evt = '0;
      tick(1);
      src_evt[1] = 1'b1;
      serve(1, "R3 re-rise triggers");
      src_evt = '0;

      // R6 done while idle is ignored
      eng_done = 1'b1;
      tick(3);
      eng_done = 1'b0;
      check(grant == 3'b000, "R6 idle done", 32'(grant), 32'h0);
      src_evt[2] = 1'b1;
      serve(2, "R6 after idle done");
      src_evt = '0;

      // R4 inhibit drops edges
      inhibit = 1'b1;
      src_evt[2] = 1'b1;
      tick(2);
      src_evt[2] = 1'b0;
      tick(1);
      inhibit = 1'b0;
      expect_idle(5, "R4 dropped pulse");
      inhibit = 1'b1;
      src_evt[2] = 1'b1;
      tick(2);
      inhibit = 1'b0;
      expect_idle(5, "R4 level across release");
      src_evt = '0;
      tick(1);
      src_evt[2] = 1'b1;
      serve(2, "R4 works after inhibit");
      src_evt = '0;

      // R9 merge of repeated edges while pending
      src_evt[0] = 1'b1;
      tick(2);
      check(grant == 3'b001, "R9 first grant", 32'(grant), 32'h1);
      src_evt[0] = 1'b0; tick(1);
      src_evt[0] = 1'b1; tick(1);
      src_evt[0] = 1'b0; tick(1);
      src_evt[0] = 1'b1; tick(1);
      src_evt[0] = 1'b0; tick(1);
      check(grant == 3'b001, "R9 grant held", 32'(grant), 32'h1);
      eng_done = 1'b1;
      tick(1);
      eng_done = 1'b0;
      expect_idle(5, "R9 single grant");

      // R7 fixed order after serving channel 0
      do_reset();
      prio_mode = 1'b0;
      set_sel(0, 1, 2);
      src_evt[0] = 1'b1;
      serve(0, "R7 warmup");
      src_evt = '0;
      tick(1);
      src_evt = 16'h0007;
      serve(0, "R7 fixed first");
      serve(1, "R7 fixed second");
      serve(2, "R7 fixed third");
      src_evt = '0;

      // R8 rotating order after serving channel 0
      do_reset();
      prio_mode = 1'b1;
      set_sel(0, 1, 2);
      src_evt[0] = 1'b1;
      serve(0, "R8 warmup");
      src_evt = '0;
      tick(1);
      src_evt = 16'h0007;
      serve(1, "R8 rotate first");
      serve(2, "R8 rotate second");
      serve(0, "R8 rotate wrap");
      src_evt = '0;
      expect_idle(5, "R8 drained");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule